// File: doc/BRIEF.md
# Polled Byte-Transfer Controller

This block sits between a host register bus and a simple byte-wide device port. The host uses four small registers to run one-byte transfers by polling. It first reads the status register until the busy flag is clear. For an outbound transfer it then loads the byte into the outbound data register. Finally it writes the control register with a direction bit and a go bit. The controller accepts the pending command and raises busy. It then moves one byte over the device port and retires the command by dropping busy and the pending flag together.

The device side has two valid/ready streams. The outbound stream is `dev_tx_*`: the controller drives valid, the device drives ready. Once `dev_tx_valid` is high it stays high, with its byte unchanged, until the device takes the byte or reports a fault. The inbound stream is `dev_rx_*`: the controller offers ready and the device drives valid. The device may hold valid back for as long as it likes. The controller asserts ready only while an inbound transfer is in progress. A fault pin lets the device abort the transfer in progress. The outcome is then reported in the error flag.

Top module: `pollctl_top`

## Requirements
- R1: Register map: offset 0 is status (bit0 busy, bit1 error, bit2 command pending). Offset 1 is control, which reads back as bit0 direction (1 = outbound/write, 0 = inbound/read) and bit1 command pending. Offset 2 is the inbound byte and offset 3 is the outbound byte. Unused bits read 0, and reset clears every register.
- R2: A host write to control with bit1 = 1 while busy is 0 sets the command pending flag on that clock. The controller sets busy on the following clock.
- R3: Accepting a command (busy rising) clears the error flag.
- R4: Any host write made while busy is 1 is ignored: direction, pending flag and the outbound byte keep their values.
- R5: During an outbound transfer, `dev_tx_valid` is high and `dev_tx_data` carries the outbound byte. Both hold steady under back-pressure until `dev_tx_ready` is seen.
- R6: During an inbound transfer, `dev_rx_ready` is high until `dev_rx_valid`. The byte is captured into the inbound register on that handshake, one clock before busy drops.
- R7: One clock after the transfer handshake, busy and command pending both clear. A transfer without a fault leaves error at 0.
- R8: A `dev_fault` during a transfer sets error and ends the transfer, and busy drops one clock later. A fault beats a handshake in the same cycle: no inbound byte is captured. Error then holds, and a fault while idle has no effect.
- R9: Host writes to status and to the inbound byte register are ignored.
- R10: At most one of `dev_tx_valid` and `dev_rx_ready` is high, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 2 | Host register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Register contents at `bus_addr` (combinational) |
| dev_tx_valid | output | 1 | Outbound byte offered |
| dev_tx_ready | input | 1 | Device takes outbound byte |
| dev_tx_data | output | 8 | Outbound byte |
| dev_rx_valid | input | 1 | Device offers inbound byte |
| dev_rx_ready | output | 1 | Controller can take inbound byte |
| dev_rx_data | input | 8 | Inbound byte |
| dev_fault | input | 1 | Device reports a failed transfer |

## Verification
Two collisions are provoked on purpose. In the first, the device raises a fault in the same cycle as a ready or valid handshake. The bench then checks that error is set and that the inbound register keeps its old byte. In the second, the host writes control and the outbound register in the middle of a transfer. Those writes must leave both registers unchanged, which the bench reads back after the command retires. A behavioural reference model in the bench runs alongside the design and compares the read data and device-port outputs on every clock.

// File: rtl/pollctl_pkg.sv
package pollctl_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RXBYTE = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_TXBYTE = 2'd3;

  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_PEND = 2;

  localparam int CT_DIR = 0;
  localparam int CT_GO  = 1;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_RUN  = 2'd1,
    XF_DONE = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/pollctl_xfer.sv
module pollctl_xfer
  import pollctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_pend,
  input  logic              dir_wr,
  input  logic              dev_fault,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  output logic              rx_ready,
  output logic              busy,
  output logic              accept,
  output logic              fault_hit,
  output logic              capture,
  output logic [DATA_W-1:0] cap_data,
  output logic              finish
);
  xfer_state_t state_q, state_d;
  logic        running;
  logic        handshake;

  assign running   = (state_q == XF_RUN);
  assign busy      = (state_q != XF_IDLE);
  assign accept    = (state_q == XF_IDLE) && cmd_pend;
  assign finish    = (state_q == XF_DONE);
  assign tx_valid  = running && dir_wr;
  assign rx_ready  = running && !dir_wr;
  assign fault_hit = running && dev_fault;
  assign handshake = (tx_valid && tx_ready) || (rx_ready && rx_valid);
  assign capture   = rx_ready && rx_valid && !dev_fault;
  assign cap_data  = rx_data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XF_IDLE: if (accept) state_d = XF_RUN;
      XF_RUN:  if (fault_hit || handshake) state_d = XF_DONE;
      XF_DONE: state_d = XF_IDLE;
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= XF_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pollctl_regs.sv
module pollctl_regs
  import pollctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              accept,
  input  logic              fault_hit,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              finish,
  output logic              dir_wr,
  output logic              cmd_pend,
  output logic              err,
  output logic [DATA_W-1:0] tx_byte
);
  logic              host_ok;
  logic [DATA_W-1:0] rx_byte;

  assign host_ok = bus_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_wr   <= 1'b0;
      cmd_pend <= 1'b0;
      err      <= 1'b0;
      tx_byte  <= '0;
      rx_byte  <= '0;
    end else begin
      if (host_ok && bus_addr == OFS_CTRL) begin
        dir_wr <= bus_wdata[CT_DIR];
        if (bus_wdata[CT_GO]) cmd_pend <= 1'b1;
      end
      if (host_ok && bus_addr == OFS_TXBYTE) tx_byte <= bus_wdata;
      if (finish)    cmd_pend <= 1'b0;
      if (accept)    err      <= 1'b0;
      if (fault_hit) err      <= 1'b1;
      if (capture)   rx_byte  <= cap_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_STATUS: begin
        bus_rdata[ST_BUSY] = busy;
        bus_rdata[ST_ERR]  = err;
        bus_rdata[ST_PEND] = cmd_pend;
      end
      OFS_CTRL: begin
        bus_rdata[CT_DIR] = dir_wr;
        bus_rdata[CT_GO]  = cmd_pend;
      end
      OFS_RXBYTE: bus_rdata = rx_byte;
      default:    bus_rdata = tx_byte;
    endcase
  end
endmodule

// File: rtl/pollctl_top.sv
module pollctl_top
  import pollctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_fault
);
  logic              busy_w, accept_w, fault_w, capture_w, finish_w;
  logic              dir_w, pend_w, err_w;
  logic [DATA_W-1:0] cap_w, txb_w;

  pollctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy_w),
    .accept   (accept_w),
    .fault_hit(fault_w),
    .capture  (capture_w),
    .cap_data (cap_w),
    .finish   (finish_w),
    .dir_wr   (dir_w),
    .cmd_pend (pend_w),
    .err      (err_w),
    .tx_byte  (txb_w)
  );

  pollctl_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_pend (pend_w),
    .dir_wr   (dir_w),
    .dev_fault(dev_fault),
    .tx_ready (dev_tx_ready),
    .rx_valid (dev_rx_valid),
    .rx_data  (dev_rx_data),
    .tx_valid (dev_tx_valid),
    .rx_ready (dev_rx_ready),
    .busy     (busy_w),
    .accept   (accept_w),
    .fault_hit(fault_w),
    .capture  (capture_w),
    .cap_data (cap_w),
    .finish   (finish_w)
  );

  assign dev_tx_data = txb_w;
endmodule

// File: rtl/pollctl_chk.sv
module pollctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              busy,
  input logic              pend,
  input logic              err,
  input logic              dir,
  input logic [DATA_W-1:0] txb,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_ready,
  input logic              fault
);
  a_r2_pending_gets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !busy |=> busy);

  a_r3_accept_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);

  a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_we |=> $stable(txb) && $stable(dir));

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !fault |=> tx_valid && $stable(tx_data));

  a_r7_retire_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pend);

  a_r8_err_rises_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready}));

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready);
endmodule

bind pollctl_top pollctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_we  (bus_we),
  .busy    (busy_w),
  .pend    (pend_w),
  .err     (err_w),
  .dir     (dir_w),
  .txb     (txb_w),
  .tx_valid(dev_tx_valid),
  .tx_ready(dev_tx_ready),
  .tx_data (dev_tx_data),
  .rx_ready(dev_rx_ready),
  .fault   (dev_fault)
);

// File: tb/pollctl_top_test.sv
module pollctl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       dev_tx_valid, dev_rx_ready;
  logic [7:0] dev_tx_data;
  logic       dev_tx_ready = 1'b0;
  logic       dev_rx_valid = 1'b0;
  logic [7:0] dev_rx_data = 8'd0;
  logic       dev_fault = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  pollctl_top uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .dev_fault(dev_fault)
  );

  // Behavioural reference model: phase 0 idle, 1 moving, 2 retiring
  int   m_phase = 0;
  bit   m_pend = 0, m_err = 0, m_dir = 0;
  byte  m_rx = 0, m_tx = 0;

  always @(posedge clk) begin
    int  ph;
    bit  pend, busy;
    ph = m_phase; pend = m_pend; busy = (m_phase != 0);
    if (!rst_n) begin
      m_phase = 0; m_pend = 0; m_err = 0; m_dir = 0; m_rx = 0; m_tx = 0;
    end else begin
      if (bus_we && !busy && bus_addr == 2'd1) begin
        m_dir = bus_wdata[0];
        if (bus_wdata[1]) m_pend = 1;
      end
      if (bus_we && !busy && bus_addr == 2'd3) m_tx = bus_wdata;
      if (ph == 0 && pend) begin m_phase = 1; m_err = 0; end
      else if (ph == 1) begin
        if (dev_fault) begin m_err = 1; m_phase = 2; end
        else if (m_dir && dev_tx_ready) m_phase = 2;
        else if (!m_dir && dev_rx_valid) begin m_rx = dev_rx_data; m_phase = 2; end
      end else if (ph == 2) begin
        m_phase = 0; m_pend = 0;
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {5'd0, m_pend, m_err, m_phase != 0};
      2'd1: return {6'd0, m_pend, m_dir};
      2'd2: return m_rx;
      default: return m_tx;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      chk(bus_rdata == model_read(bus_addr), "R1 model readback", bus_rdata, model_read(bus_addr));
      chk(dev_tx_valid == (m_phase == 1 && m_dir), "R10 tx_valid vs model",
          dev_tx_valid, (m_phase == 1 && m_dir));
      chk(dev_rx_ready == (m_phase == 1 && !m_dir), "R10 rx_ready vs model",
          dev_rx_ready, (m_phase == 1 && !m_dir));
      if (dev_tx_valid) chk(dev_tx_data == m_tx, "R5 tx_data vs model", dev_tx_data, m_tx);
    end
  end

  // tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #5 v = bus_rdata;
    @(negedge clk);
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(2'd0, v);
      if (!v[0]) return;
    end
    chk(1'b0, "R7 busy never cleared", 1, 0);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) expect_rd(a[1:0], 8'h00, "R1 reset value");

    // R5/R2/R7 outbound transfer with back-pressure
    wr(2'd3, 8'hA5);
    wr(2'd1, 8'h03);
    expect_rd(2'd0, 8'h04, "R2 pending set, not yet busy");
    expect_rd(2'd0, 8'h05, "R2 busy one clock later");
    cycles(3);
    #5 chk(dev_tx_valid && dev_tx_data == 8'hA5, "R5 held under back-pressure",
           {dev_tx_valid, dev_tx_data}, 9'h1A5);
    @(negedge clk);
    dev_tx_ready = 1'b1;
    @(negedge clk);
    dev_tx_ready = 1'b0;
    wait_idle();
    expect_rd(2'd0, 8'h00, "R7 clean retire clears flags");

    // R4/R6 inbound transfer with host writes during busy
    wr(2'd1, 8'h02);
    cycles(2);
    wr(2'd3, 8'hFF);
    wr(2'd1, 8'h03);
    dev_rx_valid = 1'b1; dev_rx_data = 8'h3C;
    @(negedge clk);
    dev_rx_valid = 1'b0;
    wait_idle();
    expect_rd(2'd2, 8'h3C, "R6 byte captured by not-busy poll");
    expect_rd(2'd3, 8'hA5, "R4 outbound byte kept");
    expect_rd(2'd1, 8'h00, "R4 control kept");

    // R8 fault with ready in the same cycle
    wr(2'd1, 8'h03);
    cycles(2);
    dev_fault = 1'b1; dev_tx_ready = 1'b1;
    @(negedge clk);
    dev_fault = 1'b0; dev_tx_ready = 1'b0;
    expect_rd(2'd0, 8'h07, "R8 error set while busy");
    wait_idle();
    expect_rd(2'd0, 8'h02, "R8 error held after retire");
    dev_fault = 1'b1;
    cycles(2);
    dev_fault = 1'b0;
    expect_rd(2'd0, 8'h02, "R8 idle fault ignored");

    // R8 fault beats inbound handshake
    wr(2'd1, 8'h02);
    cycles(2);
    dev_fault = 1'b1; dev_rx_valid = 1'b1; dev_rx_data = 8'h77;
    @(negedge clk);
    dev_fault = 1'b0; dev_rx_valid = 1'b0;
    wait_idle();
    expect_rd(2'd2, 8'h3C, "R8 no capture on faulted read");

    // R3 accept clears error
    wr(2'd1, 8'h02);
    expect_rd(2'd0, 8'h06, "R3 pending with old error");
    expect_rd(2'd0, 8'h05, "R3 error cleared on accept");
    dev_rx_valid = 1'b1; dev_rx_data = 8'h5A;
    @(negedge clk);
    dev_rx_valid = 1'b0;
    wait_idle();
    expect_rd(2'd2, 8'h5A, "R6 second inbound byte");

    // R9 read-only registers
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h00);
    expect_rd(2'd0, 8'h00, "R9 status write ignored");
    expect_rd(2'd2, 8'h5A, "R9 inbound write ignored");

    cycles(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule